// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits between a PWM generator and the output pins and overrides the two generator outputs, A and B, when a fault pin goes active. One of three fault pins is selected as the trip source. Each pin passes through a two-flop synchroniser, and then through a programmable glitch filter. The filter accepts a new level only after it has been stable for a configured number of cycles. A polarity select makes either a high or a low pin level count as the fault.

Two trip modes are offered. In one-shot mode the first filtered fault latches the override, and only a software clear pulse releases it. In cycle mode the override follows the filtered fault level, so it can trip and release any number of times. While tripped, each output applies its own action: pass, force low, force high, or toggle. The toggle action inverts the output level once on entry to the trip and then holds that level.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, both trip flags read 0 and each output equals its PWM input.
- R2: When not tripped, `pwm_a_out` and `pwm_b_out` follow `pwm_a_in` and `pwm_b_in` in the same cycle, with no register in the path.
- R3: `src_sel` values 0, 1 and 2 select `fault_pin[0]`, `[1]` and `[2]` as the trip source. The value 3 selects no source. Pins that are not selected have no effect.
- R4: With `active_low`=0 a high pin level is a fault. With `active_low`=1 a low pin level is a fault.
- R5: A pin change that lasts at least `filt_cycles`+1 cycles reaches the outputs and flags on the (4+`filt_cycles`)th rising edge after the change. A pulse of `filt_cycles` cycles or fewer is ignored.
- R6: With `oneshot_en`=1, a fault sets `ost_latched`. The override then stays in force after the pin returns to its inactive level.
- R7: A `sw_clear` pulse while the filtered fault is inactive clears the one-shot latch at the next edge. A clear in a cycle where the filtered fault is still active is ignored.
- R8: With `oneshot_en`=0, `cbc_active` and the override follow the filtered fault level. The override is released when the fault goes inactive and can trip again.
- R9: `act_a` and `act_b` are independent 2-bit action codes: 0 = pass, 1 = force low, 2 = force high, 3 = toggle.
- R10: Toggle drives the inverse of the input level sampled at the edge where the trip starts, and holds that level while the trip lasts. Each new trip samples afresh.
- R11: With action 0, the output keeps following its input while tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_in | input | 1 | Raw PWM output A from the generator |
| pwm_b_in | input | 1 | Raw PWM output B from the generator |
| fault_pin | input | SRC_N | Asynchronous fault pins |
| src_sel | input | SEL_W | Fault source select (SRC_N = none) |
| active_low | input | 1 | 1 = low pin level is the fault |
| oneshot_en | input | 1 | 1 = one-shot latch, 0 = cycle mode |
| filt_cycles | input | FILT_W | Glitch filter length in cycles |
| act_a | input | 2 | Trip action for output A |
| act_b | input | 2 | Trip action for output B |
| sw_clear | input | 1 | Software clear pulse for the one-shot latch |
| pwm_a_out | output | 1 | Final output A |
| pwm_b_out | output | 1 | Final output B |
| ost_latched | output | 1 | One-shot trip is latched |
| cbc_active | output | 1 | Cycle-mode trip is active |

## Verification
The software clear and a fault that is still active can land in the same cycle. The bench provokes this by pulsing `sw_clear` while the selected pin is held at its fault level after a one-shot trip. It judges the result by checking that `ost_latched` and the forced outputs hold through that edge and afterwards. It then releases the pin, lets the filter settle, and checks that the same pulse does clear the latch.

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard #(
  parameter int SRC_N    = 3,
  parameter int SYNC_LEN = 2,
  parameter int FILT_W   = 8,
  localparam int SEL_W   = $clog2(SRC_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_a_in,
  input  logic              pwm_b_in,
  input  logic [SRC_N-1:0]  fault_pin,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              active_low,
  input  logic              oneshot_en,
  input  logic [FILT_W-1:0] filt_cycles,
  input  logic [1:0]        act_a,
  input  logic [1:0]        act_b,
  input  logic              sw_clear,
  output logic              pwm_a_out,
  output logic              pwm_b_out,
  output logic              ost_latched,
  output logic              cbc_active
);

  logic [SYNC_LEN-1:0] sync_q [SRC_N];
  logic                sel_lvl;
  logic [FILT_W-1:0]   cnt_q;
  logic                flt_q;
  logic                ost_q, cbc_q, ost_nxt, cbc_nxt;
  logic                trip, trip_nxt;
  logic                hold_a, hold_b;

  for (genvar g = 0; g < SRC_N; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[g] <= '0;
      else        sync_q[g] <= {sync_q[g][SYNC_LEN-2:0], fault_pin[g] ^ active_low};
  end

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < SRC_N; i++)
      if (src_sel == SEL_W'(i)) sel_lvl = sync_q[i][SYNC_LEN-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (sel_lvl == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == filt_cycles) begin
      cnt_q <= '0;
      flt_q <= sel_lvl;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end

  assign ost_nxt  = (flt_q & oneshot_en) | (ost_q & ~(sw_clear & ~flt_q));
  assign cbc_nxt  = flt_q & ~oneshot_en;
  assign trip     = ost_q | cbc_q;
  assign trip_nxt = ost_nxt | cbc_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ost_q  <= 1'b0;
      cbc_q  <= 1'b0;
      hold_a <= 1'b0;
      hold_b <= 1'b0;
    end else begin
      ost_q <= ost_nxt;
      cbc_q <= cbc_nxt;
      if (trip_nxt && !trip) begin
        hold_a <= ~pwm_a_in;
        hold_b <= ~pwm_b_in;
      end
    end

  function automatic logic apply_act(input logic trp, input logic [1:0] act,
                                     input logic raw, input logic held);
    if (!trp) return raw;
    case (act)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return held;
      default: return raw;
    endcase
  endfunction

  assign pwm_a_out   = apply_act(trip, act_a, pwm_a_in, hold_a);
  assign pwm_b_out   = apply_act(trip, act_b, pwm_b_in, hold_b);
  assign ost_latched = ost_q;
  assign cbc_active  = cbc_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ost_q && !sw_clear |=> ost_q);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ost_q) |-> $past(sw_clear) && !$past(flt_q));

  p_cbc_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_q && !flt_q |=> !cbc_q);

  p_tog_static_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip && $past(trip) && act_a == 2'd3 && $past(act_a) == 2'd3 |-> $stable(pwm_a_out));

  p_tog_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> hold_b == !$past(pwm_b_in));

endmodule

// File: tb/pwm_trip_guard_tb_top.sv
`timescale 1ns/1ps
module pwm_trip_guard_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       a_in = 0, b_in = 0, act_lo = 0, os_en = 0, clr = 0;
  logic [2:0] pins = 0;
  logic [1:0] sel = 0, act_a = 0, act_b = 0;
  logic [7:0] filt = 0;
  logic       a_out, b_out, ost, cbc;
  int vec = 0, bad = 0;

  always #2.5 clk = ~clk;

  pwm_trip_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_a_in(a_in), .pwm_b_in(b_in),
    .fault_pin(pins), .src_sel(sel), .active_low(act_lo), .oneshot_en(os_en),
    .filt_cycles(filt), .act_a(act_a), .act_b(act_b), .sw_clear(clr),
    .pwm_a_out(a_out), .pwm_b_out(b_out), .ost_latched(ost), .cbc_active(cbc));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    a_in = 1; b_in = 0; #1;
    chk("R1 reset", {a_out, b_out, ost, cbc}, 4'b1000);
  endtask

  task automatic t_idle_pass();
    for (int i = 0; i < 4; i++) begin
      a_in = i[0]; b_in = i[1]; #1;
      chk("R2 idle pass", {a_out, b_out}, {i[0], i[1]});
      tick(1);
    end
  endtask

  task automatic t_cycle_latency();
    os_en = 0; act_a = 1; act_b = 2; a_in = 1; b_in = 0; sel = 0;
    pins[0] = 1;
    tick(3);
    chk("R5 before latency", {a_out, b_out, cbc}, 3'b100);
    tick(1);
    chk("R5/R9 at latency", {a_out, b_out, cbc}, 3'b011);
    pins[0] = 0;
    tick(3);
    chk("R8 held till release", {a_out, b_out, cbc}, 3'b011);
    tick(1);
    chk("R8 released", {a_out, b_out, cbc}, 3'b100);
    pins[0] = 1;
    tick(4);
    chk("R8 re-trip", {a_out, b_out, cbc, ost}, 4'b0110);
    pins[0] = 0;
    tick(6);
  endtask

  task automatic t_filter();
    filt = 3; os_en = 0; act_a = 1; act_b = 1; a_in = 1; b_in = 1;
    pins[0] = 1; tick(3); pins[0] = 0;
    tick(10);
    chk("R5 short pulse ignored", {a_out, b_out, cbc}, 3'b110);
    pins[0] = 1;
    tick(6);
    chk("R5 filtered before", {cbc}, 1'b0);
    tick(1);
    chk("R5 filtered latency", {a_out, b_out, cbc}, 3'b001);
    pins[0] = 0; tick(12);
    filt = 0;
  endtask

  task automatic t_oneshot();
    os_en = 1; act_a = 2; act_b = 1; a_in = 0; b_in = 1;
    pins[0] = 1; tick(4);
    chk("R6 latch", {a_out, b_out, ost, cbc}, 4'b1010);
    clr = 1; tick(1); clr = 0; tick(2);
    chk("R7 clear ignored while active", {a_out, b_out, ost}, 3'b101);
    pins[0] = 0; tick(10);
    chk("R6 held after pin inactive", {a_out, b_out, ost}, 3'b101);
    clr = 1; tick(1); clr = 0;
    chk("R7 clear releases", {a_out, b_out, ost}, 3'b010);
    tick(3);
    chk("R7 stays clear", {ost}, 1'b0);
    os_en = 0;
  endtask

  task automatic t_source();
    act_a = 1; act_b = 1; a_in = 1; b_in = 1; sel = 1;
    pins[0] = 1; pins[2] = 1; tick(8);
    chk("R3 unselected ignored", {a_out, b_out, cbc}, 3'b110);
    pins[1] = 1; tick(4);
    chk("R3 selected pin1", {a_out, b_out, cbc}, 3'b001);
    sel = 3; tick(8);
    chk("R3 no source", {a_out, b_out, cbc}, 3'b110);
    pins = 0; tick(6); sel = 0;
  endtask

  task automatic t_polarity();
    pins = 3'b111; act_lo = 1; tick(6);
    chk("R4 high idle with low polarity", {cbc}, 1'b0);
    pins[0] = 0; tick(4);
    chk("R4 low level trips", {a_out, cbc}, 2'b01);
    pins[0] = 1; tick(6);
    chk("R4 release", {a_out, cbc}, 2'b10);
    act_lo = 0; pins = 0; tick(6);
  endtask

  task automatic t_toggle();
    act_a = 3; act_b = 3; a_in = 1; b_in = 0;
    pins[0] = 1; tick(4);
    chk("R10 toggle entry", {a_out, b_out}, 2'b01);
    a_in = 0; b_in = 1; tick(3);
    chk("R10 toggle static", {a_out, b_out}, 2'b01);
    pins[0] = 0; tick(4);
    chk("R10 release", {a_out, b_out}, 2'b01);
    pins[0] = 1; tick(4);
    chk("R10 fresh sample", {a_out, b_out}, 2'b10);
    pins[0] = 0; tick(6);
  endtask

  task automatic t_pass_in_fault();
    act_a = 0; act_b = 2; pins[0] = 1; tick(4);
    for (int i = 0; i < 4; i++) begin
      a_in = i[0]; b_in = i[1]; #1;
      chk("R11/R9 pass during trip", {a_out, b_out, cbc}, {i[0], 2'b11});
      tick(1);
    end
    pins[0] = 0; tick(6);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    t_reset();
    t_idle_pass();
    t_cycle_latency();
    t_filter();
    t_oneshot();
    t_source();
    t_polarity();
    t_toggle();
    t_pass_in_fault();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule